// File: doc/BRIEF.md
# Multi-CPU System Interrupt Router

The router collects 32 level-sensitive hardware interrupt lines into a pending word. A per-bit disable word masks that pending word. A fixed translation table then turns every surviving source bit into a processor interrupt level between 1 and 15. The combined hard-level set goes to exactly one processor, chosen by a programmable target register. Every other processor receives an empty vector. The per-CPU interrupt blocks consume these vectors, a master-off flag and a level-15 broadcast flag. Those blocks merge the router's outputs with their own local sources.

Software reaches the router through a 32-bit word port made of valid, write, a word offset and data. It can read the pending word, read the disable word, and clear disable bits by writing ones to an enable register. It can set disable bits by writing ones to a mask register, and it can read and write the target register. Bit 31 of the disable word is a global kill: while it is set, no processor receives a hard level. Disabling a source only hides it; its pending bit keeps tracking the input line.

Top module: `sirq_router`

## Requirements
- R1: Each pending bit equals its source input one clock earlier. Source bits whose table level is 0 (bits 23, 24, 25, 26 and 31) never become pending. A read of offset 0 returns the pending word with bit 31 forced to 0.
- R2: Source bit b translates to level L(b) from this table, indexed by bit from 0 upward: 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. Level L drives bit L-1 of a CPU's 15-bit vector in `cpu_hard_lvl`; CPU c owns bits c*15 to c*15+14.
- R3: Only the CPU named by the target register receives a non-zero hard vector. All other CPUs receive zero.
- R4: The hard vector is built from pending AND NOT disabled. Setting a disable bit leaves its pending bit unchanged.
- R5: A write to offset 2 clears the disable bits where the data has ones, and a write to offset 3 sets them. Only bits within writable mask 0xF05DFF80 can change. A read of offset 1 returns the disable word ANDed with that mask.
- R6: While disable bit 31 is set, every CPU's hard vector is zero and `master_off` is 1.
- R7: Offset 4 holds the target CPU. A write keeps only the low log2(NUM_CPUS) bits, which is the value modulo NUM_CPUS. A read returns the target zero-extended.
- R8: After reset, pending is 0, the target is 0 and the disable word holds 0x0FA2007F. A read of offset 1 after reset therefore returns 0.
- R9: `lvl15_bcast` is 1 whenever any level-15 source (bits 27 to 30) is pending, whatever the disable word or the target holds.
- R10: A read returns its data on `rd_data` with `rd_valid` high in the cycle after the request. Offsets 5 to 7 read as 0. Writes to offsets 0, 1 and 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 32 | Level-sensitive hardware source lines |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word offset |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| cpu_hard_lvl | output | NUM_CPUS*15 | Per-CPU hard level vectors, bit L-1 = level L |
| master_off | output | 1 | Global kill bit state |
| lvl15_bcast | output | 1 | A level-15 source is pending |

## Verification
The bench raises each single source line in turn and rotates the target across all CPUs. This shows whether the table entry, the level-0 holes and the steering are right for every bit. It checks that the locked disable bits keep their sources silent while their pending bits still appear.

Directed sequences then set and clear one writable disable bit, toggle the global kill and write out-of-range target values. These separate masking from pending loss and separate a kill from a mis-steer. They also show whether target wrap-around is handled.

A long pseudo-random run mixes multi-bit source patterns, disable writes and target changes. Every vector is compared against an arithmetic model, which catches errors where levels combine or where two sources share a level.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  localparam int NSRC = 32;
  localparam int NLVL = 15;
  localparam logic [31:0] DIS_WMASK = 32'hF05DFF80;
  localparam logic [31:0] DIS_RESET = 32'h0FA2007F;
  localparam int KILL_BIT = 31;

  typedef enum logic [2:0] {
    OFS_PEND = 3'd0,
    OFS_DIS  = 3'd1,
    OFS_ENA  = 3'd2,
    OFS_MSK  = 3'd3,
    OFS_TGT  = 3'd4
  } reg_ofs_e;

  // Fixed source-bit to processor-level translation.
  function automatic logic [3:0] src_level(input int b);
    case (b)
      0, 7:              return 4'd2;
      1, 8:              return 4'd3;
      2, 9:              return 4'd5;
      3, 10:             return 4'd7;
      4, 11, 21:         return 4'd9;
      5, 12, 22:         return 4'd11;
      6, 13, 17:         return 4'd13;
      14, 15:            return 4'd12;
      16:                return 4'd6;
      18:                return 4'd4;
      19:                return 4'd10;
      20:                return 4'd8;
      27, 28, 29, 30:    return 4'd15;
      default:           return 4'd0;
    endcase
  endfunction

  // Sources that have a non-zero level.
  function automatic logic [31:0] live_sources();
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < NSRC; b++) m[b] = (src_level(b) != 4'd0);
    return m;
  endfunction

  // Sources that map to one given level.
  function automatic logic [31:0] sources_at(input int lvl);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < NSRC; b++) m[b] = (int'(src_level(b)) == lvl);
    return m;
  endfunction

  // Collapse an active source word into a 15-bit level vector.
  function automatic logic [NLVL-1:0] fold_levels(input logic [31:0] act);
    logic [NLVL-1:0] v;
    v = '0;
    for (int b = 0; b < NSRC; b++)
      if (act[b] && src_level(b) != 4'd0) v[src_level(b) - 4'd1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/sirq_pend_capture.sv
module sirq_pend_capture
  import sirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_in,
  output logic [31:0] pend_q,
  output logic        bcast15
);
  localparam logic [31:0] LIVE  = live_sources();
  localparam logic [31:0] TOP15 = sources_at(15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= src_in & LIVE;
  end

  assign bcast15 = |(pend_q & TOP15);
endmodule

// File: rtl/sirq_ctrl_regs.sv
module sirq_ctrl_regs
  import sirq_pkg::*;
#(
  parameter int TGT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [2:0]       req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [31:0]      pend_q,
  output logic [31:0]      dis_q,
  output logic [TGT_W-1:0] tgt_q,
  output logic             rd_valid,
  output logic [31:0]      rd_data
);
  logic        do_wr, do_rd;
  logic [31:0] wbits;
  logic [31:0] rd_mux;

  assign do_wr = req_valid &  req_write;
  assign do_rd = req_valid & ~req_write;
  assign wbits = req_wdata & DIS_WMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q <= DIS_RESET;
      tgt_q <= '0;
    end else if (do_wr) begin
      case (reg_ofs_e'(req_addr))
        OFS_ENA: dis_q <= dis_q & ~wbits;
        OFS_MSK: dis_q <= dis_q |  wbits;
        OFS_TGT: tgt_q <= req_wdata[TGT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_ofs_e'(req_addr))
      OFS_PEND: rd_mux = pend_q & ~(32'h1 << KILL_BIT);
      OFS_DIS:  rd_mux = dis_q & DIS_WMASK;
      OFS_TGT:  rd_mux = 32'(tgt_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/sirq_level_router.sv
module sirq_level_router
  import sirq_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int TGT_W    = 2
) (
  input  logic [31:0]              pend_q,
  input  logic [31:0]              dis_q,
  input  logic [TGT_W-1:0]         tgt_q,
  output logic [NUM_CPUS*NLVL-1:0] hard_lvl,
  output logic                     kill
);
  logic [31:0]     active;
  logic [NLVL-1:0] lvl_vec;

  assign kill    = dis_q[KILL_BIT];
  assign active  = pend_q & ~dis_q;
  assign lvl_vec = fold_levels(active);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic picked;
    assign picked = (tgt_q == TGT_W'(c)) && !kill;
    assign hard_lvl[c*NLVL +: NLVL] = picked ? lvl_vec : '0;
  end
endmodule

// File: rtl/sirq_router.sv
module sirq_router
  import sirq_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  localparam int TGT_W = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              src_in,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [2:0]               req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rd_valid,
  output logic [31:0]              rd_data,
  output logic [NUM_CPUS*15-1:0]   cpu_hard_lvl,
  output logic                     master_off,
  output logic                     lvl15_bcast
);
  logic [31:0]      pend_q;
  logic [31:0]      dis_q;
  logic [TGT_W-1:0] tgt_q;

  sirq_pend_capture u_pend (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .pend_q(pend_q), .bcast15(lvl15_bcast)
  );

  sirq_ctrl_regs #(.TGT_W(TGT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .pend_q(pend_q), .dis_q(dis_q), .tgt_q(tgt_q),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  sirq_level_router #(.NUM_CPUS(NUM_CPUS), .TGT_W(TGT_W)) u_route (
    .pend_q(pend_q), .dis_q(dis_q), .tgt_q(tgt_q),
    .hard_lvl(cpu_hard_lvl), .kill(master_off)
  );
endmodule

// File: rtl/sirq_router_chk.sv
module sirq_router_chk
  import sirq_pkg::*;
#(
  parameter int NUM_CPUS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [31:0]              src_in,
  input logic                     req_valid,
  input logic                     req_write,
  input logic                     rd_valid,
  input logic [31:0]              pend_q,
  input logic [31:0]              dis_q,
  input logic [NUM_CPUS*15-1:0]   cpu_hard_lvl,
  input logic                     lvl15_bcast
);
  localparam logic [31:0] LIVE = live_sources();

  logic armed;
  logic [NUM_CPUS-1:0] cpu_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_busy
    assign cpu_busy[c] = |cpu_hard_lvl[c*15 +: 15];
  end

  // R1: pending tracks the live inputs of the previous cycle
  a_r1_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (pend_q == ($past(src_in) & LIVE)));

  // R3: at most one CPU receives hard levels
  a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_busy));

  // R6: kill bit silences every CPU
  a_r6_kill_silent: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q[KILL_BIT] |-> (cpu_busy == '0));

  // R5: bits outside the writable mask keep their reset value
  a_r5_locked_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q & ~DIS_WMASK) == (DIS_RESET & ~DIS_WMASK));

  // R9: a rising level-15 line shows up on the broadcast flag
  a_r9_bcast_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(src_in[28]) |=> lvl15_bcast);

  // R10: read answers one cycle after the request
  a_r10_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
endmodule

bind sirq_router sirq_router_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in),
  .req_valid(req_valid), .req_write(req_write), .rd_valid(rd_valid),
  .pend_q(pend_q), .dis_q(dis_q),
  .cpu_hard_lvl(cpu_hard_lvl), .lvl15_bcast(lvl15_bcast)
);

// File: tb/sirq_router_tb.sv
module sirq_router_tb_top;
  localparam int NC = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [31:0]    src_in = '0;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [2:0]     req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           rd_valid;
  logic [31:0]    rd_data;
  logic [NC*15-1:0] cpu_hard_lvl;
  logic           master_off;
  logic           lvl15_bcast;

  int n_cmp = 0;
  int n_bad = 0;

  // spec table
  int LT [32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                  6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};

  // bench-side model state
  logic [31:0] m_dis;
  int          m_tgt;
  logic [31:0] m_src;

  always #10 clk = ~clk;

  sirq_router #(.NUM_CPUS(NC)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cpu_hard_lvl(cpu_hard_lvl), .master_off(master_off),
    .lvl15_bcast(lvl15_bcast)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pend(input logic [31:0] s);
    logic [31:0] p = '0;
    for (int b = 0; b < 32; b++) if (s[b] && LT[b] > 0) p[b] = 1'b1;
    return p;
  endfunction

  // levels computed per level: OR over all sources carrying that level
  function automatic logic [14:0] exp_levels(input logic [31:0] act);
    logic [14:0] v = '0;
    for (int L = 1; L <= 15; L++)
      for (int b = 0; b < 32; b++) if (LT[b] == L && act[b]) v[L-1] = 1'b1;
    return v;
  endfunction

  function automatic logic [NC*15-1:0] exp_hard();
    logic [NC*15-1:0] h = '0;
    logic [14:0] v = exp_levels(exp_pend(m_src) & ~m_dis);
    if (!m_dis[31]) h[m_tgt*15 +: 15] = v;
    return h;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (a == 3'd2) m_dis = m_dis & ~(d & 32'hF05DFF80);
    if (a == 3'd3) m_dis = m_dis |  (d & 32'hF05DFF80);
    if (a == 3'd4) m_tgt = int'(d % NC);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rd_valid === 1'b1, "R10 rd_valid", 64'(rd_valid), 64'd1);
    d = rd_data;
  endtask

  task automatic drive_src(input logic [31:0] s);
    @(negedge clk);
    src_in = s; m_src = s;
    @(negedge clk);
  endtask

  task automatic check_outputs(input string req);
    chk(cpu_hard_lvl === exp_hard(), req, 64'(cpu_hard_lvl), 64'(exp_hard()));
    chk(master_off === m_dis[31], {req, " R6 master_off"}, 64'(master_off), 64'(m_dis[31]));
    chk(lvl15_bcast === |(exp_pend(m_src) & 32'h78000000), {req, " R9 bcast"},
        64'(lvl15_bcast), 64'(|(exp_pend(m_src) & 32'h78000000)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] lf;
    m_dis = 32'h0FA2007F; m_tgt = 0; m_src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    rd(3'd0, r); chk(r === 32'h0, "R8 pending after reset", 64'(r), 64'h0);
    rd(3'd1, r); chk(r === 32'h0, "R8 disabled read after reset", 64'(r), 64'h0);
    rd(3'd4, r); chk(r === 32'h0, "R8 target after reset", 64'(r), 64'h0);
    check_outputs("R8 outputs after reset");

    // R5 enable all writable bits; locked bits stay disabled
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd1, r); chk(r === 32'h0, "R5 disabled after enable-all", 64'(r), 64'h0);

    // R1 R2 R3 single-source sweep with rotating target
    for (int j = 0; j < 32; j++) begin
      wr(3'd4, 32'(j % NC));
      drive_src(32'h1 << j);
      rd(3'd0, r);
      chk(r === (exp_pend(32'h1 << j) & 32'h7FFFFFFF), "R1 pending read", 64'(r),
          64'(exp_pend(32'h1 << j) & 32'h7FFFFFFF));
      check_outputs("R2 R3 single source");
    end

    // R4 disable hides but keeps pending (bit 16 -> level 6)
    wr(3'd4, 32'd1);
    drive_src(32'h0001_0000);
    check_outputs("R4 enabled bit16");
    chk(cpu_hard_lvl[15 + 5] === 1'b1, "R2 bit16 level6 on cpu1", 64'(cpu_hard_lvl), 64'h0);
    wr(3'd3, 32'h0001_0000);
    check_outputs("R4 disabled bit16");
    rd(3'd0, r); chk(r === 32'h0001_0000, "R4 pending kept", 64'(r), 64'h0001_0000);
    rd(3'd1, r); chk(r === 32'h0001_0000, "R5 disable readback", 64'(r), 64'h0001_0000);
    wr(3'd2, 32'h0001_0000);
    check_outputs("R4 re-enabled bit16");

    // R5 locked bits ignore writes
    wr(3'd2, 32'h0FA2007F);
    drive_src(32'h0000_0001);
    check_outputs("R5 locked bit0 stays disabled");
    wr(3'd3, 32'h0FA2007F);
    rd(3'd1, r); chk(r === 32'h0, "R5 locked set ignored", 64'(r), 64'h0);

    // R6 kill bit with level-15 source present
    drive_src(32'h1000_0000 | 32'h0000_0100);
    check_outputs("R9 level15 before kill");
    wr(3'd3, 32'h8000_0000);
    check_outputs("R6 kill set");
    chk(cpu_hard_lvl === '0, "R6 all silent", 64'(cpu_hard_lvl), 64'h0);
    rd(3'd1, r); chk(r === 32'h8000_0000, "R6 kill readback", 64'(r), 64'h8000_0000);
    wr(3'd2, 32'h8000_0000);
    check_outputs("R6 kill cleared");

    // R7 target modulo
    wr(3'd4, 32'd6);
    rd(3'd4, r); chk(r === 32'd2, "R7 target wrap 6", 64'(r), 64'd2);
    wr(3'd4, 32'hFFFF_FFF3);
    rd(3'd4, r); chk(r === 32'd3, "R7 target wrap high bits", 64'(r), 64'd3);
    check_outputs("R7 steered after wrap");

    // R10 ignored writes and unmapped reads
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd1, r); chk(r === 32'h0, "R10 write to ro offsets ignored", 64'(r), 64'h0);
    rd(3'd0, r); chk(r === exp_pend(m_src), "R10 pending unchanged", 64'(r), 64'(exp_pend(m_src)));
    rd(3'd5, r); chk(r === 32'h0, "R10 offset5 reads zero", 64'(r), 64'h0);
    rd(3'd7, r); chk(r === 32'h0, "R10 offset7 reads zero", 64'(r), 64'h0);
    check_outputs("R10 state unchanged");

    // mixed pseudo-random patterns R2 R3 R4 R6
    lf = 32'hACE1_2357;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (k % 4)
        0: wr(3'd3, lf & 32'h1234_5680);
        1: wr(3'd2, ~lf);
        2: wr(3'd4, lf);
        default: ;
      endcase
      drive_src(lf ^ {lf[15:0], lf[31:16]});
      check_outputs("R2 R3 R4 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule